// File: doc/BRIEF.md
# Reference-Based Clock Frequency Meter

This block measures the frequency of one of several probe clocks against a reference clock whose rate is known and programmed as a register value in kHz. A write to the source-select input starts a measurement. The block first waits a programmable number of reference cycles so that an upstream clock multiplexer can settle. It then opens a counting window that lasts a power-of-two number of microseconds. A counter clocked by the selected probe clock counts edges while the window is open.

The window enable crosses into the probe domain through a synchronizer and is echoed back. When the echo has fallen, the probe count is stable, and the reference domain samples it. The count is scaled to kHz with a shift and compared with a programmable minimum and maximum. The block then reports the result with a done flag and one of three verdict flags. Software writes the select, polls done, and reads the result and verdict. A select value of zero parks the meter.

Top module: `refclk_freq_meter`

## Requirements
- R1: While reset is applied and just after it, st_running, st_done, st_pass, st_fast, st_slow and res_khz are all zero.
- R2: A cycle with cfg_wr high and cfg_src nonzero makes st_running high and st_done, st_pass, st_fast and st_slow low in the next cycle.
- R3: A write with cfg_src equal to 0 measures nothing. From the next cycle st_running and st_done stay low until the next write.
- R4: Counting begins only after cfg_settle reference cycles. Each extra cycle of settle delay lengthens the run by exactly one cycle.
- R5: The counting window lasts (cfg_ref_khz / 1000) << cfg_exp reference cycles, using integer division. When the count has been brought back, st_running falls and st_done rises in the same cycle. The run lasts between delay + window + 2 and delay + window + 24 cycles.
- R6: res_khz equals (probe edge count × 1000) >> cfg_exp, saturated to the result width. It is within ((3 × 1000) >> cfg_exp) + 2 kHz of the probe clock's true frequency.
- R7: While st_done is high, res_khz and the three verdict flags keep their values, whatever happens on the limit inputs, until the next write.
- R8: When done, st_pass is set if cfg_min_khz ≤ res_khz ≤ cfg_max_khz, st_fast if res_khz > cfg_max_khz, and st_slow if res_khz < cfg_min_khz. While st_done is low, all three are low.
- R9: A write during a run abandons that run and starts over. The run length and the result then follow the settings of the latest write.
- R10: cfg_src value k (1 to NSRC) selects probe_clks[k-1] as the clock under test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_clks | input | NSRC | Candidate clocks under test |
| cfg_wr | input | 1 | Write strobe for the source select; starts a run |
| cfg_src | input | SRC_W | Source select, 0 = none, k = probe_clks[k-1] |
| cfg_settle | input | DLY_W | Settle delay in reference cycles |
| cfg_exp | input | EXP_W | Window exponent; window is 2^cfg_exp microseconds |
| cfg_ref_khz | input | REF_W | Reference frequency in kHz |
| cfg_min_khz | input | KHZ_W | Lower pass limit in kHz |
| cfg_max_khz | input | KHZ_W | Upper pass limit in kHz |
| res_khz | output | KHZ_W | Measured frequency in kHz, valid while st_done |
| st_running | output | 1 | A measurement is in progress |
| st_done | output | 1 | Result and verdict are valid |
| st_pass | output | 1 | Result lies within the limits |
| st_fast | output | 1 | Result exceeds the upper limit |
| st_slow | output | 1 | Result is below the lower limit |

## Verification
The assertions check the status behaviour on every cycle. A write clears done and starts or parks the run. Done and running never coexist. The result and verdict are frozen while done is held. Pass excludes the other two verdicts, and no verdict shows without done. A run that ends without a write always ends in done. Only the bench scenarios can show the quantitative behaviour. These are the run length as a function of settle delay and window exponent, the kHz accuracy for clocks of different rates, the choice of clock by select value, and the restart of an aborted run.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [1:0] {
        FM_IDLE   = 2'd0,
        FM_SETTLE = 2'd1,
        FM_COUNT  = 2'd2,
        FM_DRAIN  = 2'd3
    } fm_state_e;

    localparam int FM_KHZ_PER_MHZ = 1000;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = d;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/fm_probe_cnt.sv
module fm_probe_cnt #(
    parameter int CNT_W  = 24,
    parameter int SYNC_N = 2
) (
    input  logic             probe_clk,
    input  logic             rst_n,
    input  logic             gate_ref,
    output logic             gate_seen,
    output logic [CNT_W-1:0] edge_cnt
);
    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } pc_state_t;

    pc_state_t cur_q, nxt_d;
    logic      gate_s;

    fm_sync #(.STAGES(SYNC_N)) u_gate_sync (
        .clk  (probe_clk),
        .rst_n(rst_n),
        .d    (gate_ref),
        .q    (gate_s)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.prev = gate_s;
        if (gate_s && !cur_q.prev) begin
            nxt_d.cnt = CNT_W'(1);
        end else if (gate_s && (cur_q.cnt != '1)) begin
            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge probe_clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign gate_seen = gate_s;
    assign edge_cnt  = cur_q.cnt;
endmodule

// File: rtl/fm_judge.sv
module fm_judge #(
    parameter int CNT_W = 24,
    parameter int EXP_W = 4,
    parameter int KHZ_W = 25
) (
    input  logic [CNT_W-1:0] edge_cnt,
    input  logic [EXP_W-1:0] shift,
    input  logic [KHZ_W-1:0] lo_khz,
    input  logic [KHZ_W-1:0] hi_khz,
    output logic [KHZ_W-1:0] khz,
    output logic             pass,
    output logic             fast,
    output logic             slow
);
    localparam int PROD_W = CNT_W + 10;

    logic [PROD_W-1:0] prod, scaled;

    always_comb begin
        prod   = PROD_W'(edge_cnt) * PROD_W'(fm_pkg::FM_KHZ_PER_MHZ);
        scaled = prod >> shift;
    end

    generate
        if (PROD_W > KHZ_W) begin : g_sat
            always_comb khz = (|scaled[PROD_W-1:KHZ_W]) ? '1 : scaled[KHZ_W-1:0];
        end else begin : g_wide
            always_comb khz = KHZ_W'(scaled);
        end
    endgenerate

    always_comb begin
        fast = khz > hi_khz;
        slow = khz < lo_khz;
        pass = !fast && !slow;
    end
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl #(
    parameter int NSRC  = 3,
    parameter int SRC_W = 2,
    parameter int DLY_W = 8,
    parameter int EXP_W = 4,
    parameter int REF_W = 20,
    parameter int KHZ_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [DLY_W-1:0] cfg_settle,
    input  logic [EXP_W-1:0] cfg_exp,
    input  logic [REF_W-1:0] cfg_ref_khz,
    input  logic             echo,
    input  logic [KHZ_W-1:0] j_khz,
    input  logic             j_pass,
    input  logic             j_fast,
    input  logic             j_slow,
    output logic             gate,
    output logic [SRC_W-1:0] src_sel,
    output logic [EXP_W-1:0] exp_sel,
    output logic [KHZ_W-1:0] res_khz,
    output logic             running,
    output logic             done,
    output logic             pass,
    output logic             fast,
    output logic             slow
);
    import fm_pkg::*;

    localparam int TMR_W = REF_W + (1 << EXP_W);

    typedef struct packed {
        fm_state_e        st;
        logic [TMR_W-1:0] tmr;
        logic             seen;
        logic             gate;
        logic [SRC_W-1:0] src;
        logic [EXP_W-1:0] ex;
        logic             done;
        logic             pass;
        logic             fast;
        logic             slow;
        logic [KHZ_W-1:0] res;
    } ctl_state_t;

    ctl_state_t cur_q, nxt_d;
    logic [REF_W-1:0] us_cyc;
    logic [TMR_W-1:0] win_cyc;
    logic             src_ok;

    always_comb begin
        us_cyc = cfg_ref_khz / REF_W'(FM_KHZ_PER_MHZ);
        if (us_cyc == '0) us_cyc = REF_W'(1);
        win_cyc = TMR_W'(us_cyc) << cur_q.ex;
        src_ok  = (cfg_src != '0) && (int'(cfg_src) <= NSRC);
    end

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            FM_IDLE: ;
            FM_SETTLE: begin
                if (cur_q.tmr != '0) begin
                    nxt_d.tmr = cur_q.tmr - TMR_W'(1);
                end else if (!echo) begin
                    nxt_d.st   = FM_COUNT;
                    nxt_d.gate = 1'b1;
                    nxt_d.seen = 1'b0;
                    nxt_d.tmr  = win_cyc - TMR_W'(1);
                end
            end
            FM_COUNT: begin
                if (echo) nxt_d.seen = 1'b1;
                if (cur_q.tmr != '0) begin
                    nxt_d.tmr = cur_q.tmr - TMR_W'(1);
                end else if (cur_q.seen || echo) begin
                    nxt_d.gate = 1'b0;
                    nxt_d.st   = FM_DRAIN;
                end
            end
            FM_DRAIN: begin
                if (!echo) begin
                    nxt_d.st   = FM_IDLE;
                    nxt_d.done = 1'b1;
                    nxt_d.res  = j_khz;
                    nxt_d.pass = j_pass;
                    nxt_d.fast = j_fast;
                    nxt_d.slow = j_slow;
                end
            end
            default: nxt_d.st = FM_IDLE;
        endcase

        if (cfg_wr) begin
            nxt_d.src  = cfg_src;
            nxt_d.ex   = cfg_exp;
            nxt_d.gate = 1'b0;
            nxt_d.seen = 1'b0;
            nxt_d.done = 1'b0;
            nxt_d.pass = 1'b0;
            nxt_d.fast = 1'b0;
            nxt_d.slow = 1'b0;
            if (src_ok) begin
                nxt_d.st  = FM_SETTLE;
                nxt_d.tmr = TMR_W'(cfg_settle);
            end else begin
                nxt_d.st  = FM_IDLE;
                nxt_d.tmr = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign gate    = cur_q.gate;
    assign src_sel = cur_q.src;
    assign exp_sel = cur_q.ex;
    assign res_khz = cur_q.res;
    assign running = cur_q.st != FM_IDLE;
    assign done    = cur_q.done;
    assign pass    = cur_q.pass;
    assign fast    = cur_q.fast;
    assign slow    = cur_q.slow;
endmodule

// File: rtl/refclk_freq_meter.sv
module refclk_freq_meter #(
    parameter int NSRC   = 3,
    parameter int CNT_W  = 24,
    parameter int DLY_W  = 8,
    parameter int EXP_W  = 4,
    parameter int REF_W  = 20,
    parameter int KHZ_W  = 25,
    parameter int SYNC_N = 2,
    localparam int SRC_W = $clog2(NSRC + 1)
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  probe_clks,
    input  logic             cfg_wr,
    input  logic [SRC_W-1:0] cfg_src,
    input  logic [DLY_W-1:0] cfg_settle,
    input  logic [EXP_W-1:0] cfg_exp,
    input  logic [REF_W-1:0] cfg_ref_khz,
    input  logic [KHZ_W-1:0] cfg_min_khz,
    input  logic [KHZ_W-1:0] cfg_max_khz,
    output logic [KHZ_W-1:0] res_khz,
    output logic             st_running,
    output logic             st_done,
    output logic             st_pass,
    output logic             st_fast,
    output logic             st_slow
);
    logic             gate, gate_seen, echo, probe_clk;
    logic [SRC_W-1:0] src_sel;
    logic [EXP_W-1:0] exp_sel;
    logic [CNT_W-1:0] edge_cnt;
    logic [KHZ_W-1:0] j_khz;
    logic             j_pass, j_fast, j_slow;

    always_comb begin
        probe_clk = 1'b0;
        for (int k = 0; k < NSRC; k++) begin
            if (src_sel == SRC_W'(k + 1)) probe_clk = probe_clks[k];
        end
    end

    fm_probe_cnt #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_probe (
        .probe_clk(probe_clk),
        .rst_n    (rst_n),
        .gate_ref (gate),
        .gate_seen(gate_seen),
        .edge_cnt (edge_cnt)
    );

    fm_sync #(.STAGES(SYNC_N)) u_echo_sync (
        .clk  (clk_ref),
        .rst_n(rst_n),
        .d    (gate_seen),
        .q    (echo)
    );

    fm_judge #(.CNT_W(CNT_W), .EXP_W(EXP_W), .KHZ_W(KHZ_W)) u_judge (
        .edge_cnt(edge_cnt),
        .shift   (exp_sel),
        .lo_khz  (cfg_min_khz),
        .hi_khz  (cfg_max_khz),
        .khz     (j_khz),
        .pass    (j_pass),
        .fast    (j_fast),
        .slow    (j_slow)
    );

    fm_ctrl #(
        .NSRC(NSRC), .SRC_W(SRC_W), .DLY_W(DLY_W),
        .EXP_W(EXP_W), .REF_W(REF_W), .KHZ_W(KHZ_W)
    ) u_ctrl (
        .clk        (clk_ref),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_src    (cfg_src),
        .cfg_settle (cfg_settle),
        .cfg_exp    (cfg_exp),
        .cfg_ref_khz(cfg_ref_khz),
        .echo       (echo),
        .j_khz      (j_khz),
        .j_pass     (j_pass),
        .j_fast     (j_fast),
        .j_slow     (j_slow),
        .gate       (gate),
        .src_sel    (src_sel),
        .exp_sel    (exp_sel),
        .res_khz    (res_khz),
        .running    (st_running),
        .done       (st_done),
        .pass       (st_pass),
        .fast       (st_fast),
        .slow       (st_slow)
    );
endmodule

// File: rtl/fm_check.sv
module fm_check #(
    parameter int NSRC  = 3,
    parameter int SRC_W = 2,
    parameter int KHZ_W = 25
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [SRC_W-1:0] cfg_src,
    input logic [KHZ_W-1:0] res_khz,
    input logic             st_running,
    input logic             st_done,
    input logic             st_pass,
    input logic             st_fast,
    input logic             st_slow
);
    logic start_ok;
    assign start_ok = (cfg_src != '0) && (int'(cfg_src) <= NSRC);

    AST_WR_CLEARS_DONE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cfg_wr |=> !st_done); // R2
    AST_WR_STARTS_RUN: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cfg_wr && start_ok) |=> st_running); // R2
    AST_ZERO_PARKS: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (cfg_wr && cfg_src == '0) |=> (!st_running && !st_done)); // R3
    AST_END_GIVES_DONE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ($fell(st_running) && !$past(cfg_wr)) |-> st_done); // R5
    AST_DONE_IDLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
        st_done |-> !st_running); // R7
    AST_HOLD_RESULT: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (st_done && !cfg_wr) |=> (st_done && $stable(res_khz) && $stable({st_pass, st_fast, st_slow}))); // R7
    AST_PASS_EXCL: assert property (@(posedge clk_ref) disable iff (!rst_n)
        st_pass |-> (!st_fast && !st_slow)); // R8
    AST_NO_VERDICT_EARLY: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !st_done |-> !(st_pass || st_fast || st_slow)); // R8
endmodule

bind refclk_freq_meter fm_check #(.NSRC(NSRC), .SRC_W(SRC_W), .KHZ_W(KHZ_W)) u_fm_check (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_src   (cfg_src),
    .res_khz   (res_khz),
    .st_running(st_running),
    .st_done   (st_done),
    .st_pass   (st_pass),
    .st_fast   (st_fast),
    .st_slow   (st_slow)
);

// File: tb/sim_refclk_freq_meter.sv
`timescale 1ns/1ps
module sim_refclk_freq_meter;
    localparam int KMAX = 25'h1FFFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  pclk = 3'b000;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_src = '0;
    logic [7:0]  cfg_settle = '0;
    logic [3:0]  cfg_exp = '0;
    logic [19:0] cfg_ref_khz = 20'd125000;
    logic [24:0] cfg_min_khz = '0;
    logic [24:0] cfg_max_khz = 25'h1FFFFFF;
    logic [24:0] res_khz;
    logic        st_running, st_done, st_pass, st_fast, st_slow;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;          // 125 MHz reference
    always #5 pclk[0] = ~pclk[0];  // 100 MHz
    always #12 pclk[1] = ~pclk[1]; // ~41.667 MHz
    always #3 pclk[2] = ~pclk[2];  // ~166.667 MHz

    refclk_freq_meter u0 (
        .clk_ref(clk), .rst_n(rst_n), .probe_clks(pclk),
        .cfg_wr(cfg_wr), .cfg_src(cfg_src), .cfg_settle(cfg_settle),
        .cfg_exp(cfg_exp), .cfg_ref_khz(cfg_ref_khz),
        .cfg_min_khz(cfg_min_khz), .cfg_max_khz(cfg_max_khz),
        .res_khz(res_khz), .st_running(st_running), .st_done(st_done),
        .st_pass(st_pass), .st_fast(st_fast), .st_slow(st_slow)
    );

    function automatic int true_khz(input int src);
        case (src)
            1: return 100000;
            2: return 41667;
            default: return 166667;
        endcase
    endfunction

    function automatic int tol_khz(input int ex);
        return ((3 * 1000) >> ex) + 2;
    endfunction

    function automatic int win_cycles(input int ex);
        return (125000 / 1000) << ex;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_meas(input int src, input int dly, input int ex,
                            input int lo, input int hi, output int len);
        @(negedge clk);
        cfg_src = 2'(src); cfg_settle = 8'(dly); cfg_exp = 4'(ex);
        cfg_min_khz = 25'(lo); cfg_max_khz = 25'(hi); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        check(st_running && !st_done && !st_pass && !st_fast && !st_slow, "R2",
              "run starts, status cleared", {st_running, st_done}, 2'b10);
        len = 0;
        while (st_running && len < 20000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic judge_run(input int src, input int dly, input int ex,
                             input int lo, input int hi, input int len, input int slack);
        int f, d, w;
        bit ep, ef, es;
        f = true_khz(src);
        w = win_cycles(ex);
        check(st_done && !st_running, "R5", "done after run", st_done, 1);
        check(len >= dly + w + 2 && len <= dly + w + 24 + slack, "R4",
              "run length vs settle+window", len, dly + w + 2);
        d = int'(res_khz) - f;
        if (d < 0) d = -d;
        check(d <= tol_khz(ex), "R6", "result kHz", res_khz, f);
        ef = f > hi; es = f < lo; ep = !ef && !es;
        check(st_pass == ep && st_fast == ef && st_slow == es, "R8",
              "verdict pass/fast/slow", {st_pass, st_fast, st_slow}, {ep, ef, es});
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int len, r1, r2, r3, r_hold;
        bit held;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        check(!st_running && !st_done && !st_pass && !st_fast && !st_slow && res_khz == 0,
              "R1", "outputs in reset", {st_running, st_done, res_khz}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!st_running && !st_done && res_khz == 0, "R1", "outputs after reset",
              {st_running, st_done}, 0);

        // R4: settle delay 0 and 200 with the same window
        run_meas(1, 0, 2, 0, KMAX, len);
        judge_run(1, 0, 2, 0, KMAX, len, 0);
        r1 = len;
        run_meas(1, 200, 2, 0, KMAX, len);
        judge_run(1, 200, 2, 0, KMAX, len, 0);
        check((len - r1) >= 196 && (len - r1) <= 204, "R4", "delay adds cycles", len - r1, 200);

        // R5: window doubles with exponent
        run_meas(1, 0, 3, 0, KMAX, len);
        judge_run(1, 0, 3, 0, KMAX, len, 0);
        check((len - r1) >= 496 && (len - r1) <= 504, "R5", "window doubling", len - r1, 500);

        // R10: each select picks its own clock
        run_meas(2, 5, 1, 0, KMAX, len);
        judge_run(2, 5, 1, 0, KMAX, len, 0);
        r2 = int'(res_khz);
        run_meas(3, 5, 0, 0, KMAX, len);
        judge_run(3, 5, 0, 0, KMAX, len, 0);
        r3 = int'(res_khz);
        check(r2 < 50000 && r3 > 150000, "R10", "select 2 vs 3 distinct", r3 - r2, 125000);

        // R8: fast and slow corners
        run_meas(1, 3, 2, 0, 0, len);
        judge_run(1, 3, 2, 0, 0, len, 0);
        run_meas(2, 3, 2, KMAX, KMAX, len);
        judge_run(2, 3, 2, KMAX, KMAX, len, 0);

        // R7: result and verdict held while limits move
        run_meas(3, 0, 1, 0, KMAX, len);
        judge_run(3, 0, 1, 0, KMAX, len, 0);
        r_hold = int'(res_khz);
        held = 1'b1;
        for (int i = 0; i < 40; i++) begin
            cfg_min_khz = 25'($urandom);
            cfg_max_khz = 25'($urandom);
            @(negedge clk);
            if (!st_done || int'(res_khz) != r_hold || !st_pass || st_fast || st_slow) held = 1'b0;
        end
        check(held, "R7", "hold while done", res_khz, r_hold);

        // R9: abort a run in its counting window
        run_meas(2, 0, 3, 0, KMAX, len);
        @(negedge clk);
        cfg_src = 2'd2; cfg_exp = 4'd3; cfg_settle = 0; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        repeat (300) @(negedge clk);
        check(st_running && !st_done, "R9", "still running mid-window", st_running, 1);
        run_meas(3, 10, 1, 0, KMAX, len);
        judge_run(3, 10, 1, 0, KMAX, len, 20);
        check(len < 600, "R9", "restart follows latest write", len, 10 + 250);

        // R3: zero select parks the meter
        run_meas(1, 0, 0, 0, KMAX, len);
        @(negedge clk);
        cfg_src = 2'd0; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        held = 1'b1;
        for (int i = 0; i < 100; i++) begin
            if (st_running || st_done) held = 1'b0;
            @(negedge clk);
        end
        check(held, "R3", "select 0 stays idle", {st_running, st_done}, 0);

        // random runs against limits placed around the nominal frequency
        for (int i = 0; i < 12; i++) begin
            int src, dly, ex, lo, hi, f;
            src = 1 + int'($urandom % 3);
            dly = int'($urandom % 60);
            ex  = int'($urandom % 4);
            f   = true_khz(src);
            case ($urandom % 3)
                0: begin lo = f - 20000; hi = f + 20000; end
                1: begin lo = 0;         hi = f - 20000; end
                default: begin lo = f + 20000; hi = KMAX; end
            endcase
            run_meas(src, dly, ex, lo, hi, len);
            judge_run(src, dly, ex, lo, hi, len, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule